// File: doc/BRIEF.md
# Predicated Commit Stage with Deferred Faults

This block is the last stage of an in-order pipeline. It owns a small register file in which every register has a one-bit poison tag. Each retiring instruction brings a destination index, a result word, two source indices, a predicate register index, a speculative flag and an exception code. The stage decides whether the result is written, whether the instruction is squashed to a no-op, whether the destination is poisoned instead of trapping, or whether a fault is raised.

The predicate is read through its own read port. When an older instruction that produces the predicate is still in flight, its value is taken from a bypass if it is ready in the same cycle. Otherwise the stage stalls and the instruction waits in order. A check operation tests the poison tag of one register and, if the tag is set, sends a recovery request rather than a fault. Faults and recovery requests are single-cycle strobes, each carrying a register index. A combinational read port lets the rest of the pipeline inspect any register and its tag.

Top module: `spec_commit`

## Requirements
- R1: An instruction whose predicate is false completes as a no-op. It writes nothing and raises neither a fault nor a recovery request, even if its sources are poisoned. A predicate is true when its register value is nonzero. Register 0 as a predicate is always false.
- R2: While `in_valid`, `pfw_busy` and not `pfw_ready` hold together, `stall_o` is high and nothing retires. When `pfw_busy` and `pfw_ready` are both high, `pfw_value` replaces the register-file value of the predicate.
- R3: A speculative instruction (`in_spec`=1) with a fatal exception (`in_exc`=2'b10 or 2'b11) raises no fault. Its destination gets the poison tag set and its data becomes zero.
- R4: A non-speculative execute instruction that reads a poisoned source raises a fatal fault (`fault_fatal`=1). The fault carries that source's index, with source A checked before source B. No write happens.
- R5: A non-speculative instruction with a fatal exception and clean sources raises a fatal fault carrying its destination index. No write happens.
- R6: A resumable exception (`in_exc`=2'b01) with clean sources raises a fault with `fault_fatal`=0 carrying the destination index, whether or not the instruction is speculative. No write happens.
- R7: A check operation (`in_chk`=1) tests the poison tag of source A. If the tag is set, `recov_o` pulses with that index and no fault is raised. If the tag is clear, nothing happens.
- R8: A clean execute instruction with no exception writes `in_data` to its destination and clears the destination's poison tag.
- R9: A speculative execute instruction that reads a poisoned source raises no fault. It poisons its destination and sets that register's data to zero.
- R10: Register 0 always reads as zero with a clear tag and ignores every write.
- R11: Reset clears all registers and tags and drives `fault_o`, `recov_o` low. Faults and recovery requests appear one cycle after the retiring edge and last one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented for retirement |
| in_chk | input | 1 | 1 = check operation, 0 = execute operation |
| in_spec | input | 1 | Instruction was hoisted speculatively |
| in_exc | input | 2 | 00 none, 01 resumable, 1x fatal |
| in_dst | input | AW | Destination register index |
| in_src_a | input | AW | First source index (the tested register for a check) |
| in_src_b | input | AW | Second source index |
| in_pred | input | AW | Predicate register index |
| in_data | input | DW | Result word |
| pfw_busy | input | 1 | An in-flight instruction produces this predicate |
| pfw_ready | input | 1 | Bypassed predicate is available this cycle |
| pfw_value | input | 1 | Bypassed predicate truth value |
| stall_o | output | 1 | Retirement is held waiting for the predicate |
| fault_o | output | 1 | Fault strobe |
| fault_fatal | output | 1 | 1 = fatal fault, 0 = resumable |
| fault_reg | output | AW | Register index tied to the fault |
| recov_o | output | 1 | Recovery request strobe |
| recov_reg | output | AW | Register whose poison triggered recovery |
| rd_idx | input | AW | Inspection read index |
| rd_data | output | DW | Inspection read data |
| rd_nat | output | 1 | Inspection poison tag |

## Verification
The assertions rely on a few input conditions. A stalled instruction stays on the inputs unchanged. The bypass signals are meaningful only while `in_valid` is high. `in_exc` takes one of its three defined meanings. The stimulus meets these conditions by driving every input on the falling edge and presenting each instruction for exactly one retiring edge. During the stall sequence it holds the instruction steady and raises `pfw_ready` only after several stalled cycles. It returns `in_valid` to zero between instructions, so each strobe can be attributed to a single retirement.

// File: rtl/spec_commit.sv
module spec_commit #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_chk,
  input  logic          in_spec,
  input  logic [1:0]    in_exc,
  input  logic [AW-1:0] in_dst,
  input  logic [AW-1:0] in_src_a,
  input  logic [AW-1:0] in_src_b,
  input  logic [AW-1:0] in_pred,
  input  logic [DW-1:0] in_data,
  input  logic          pfw_busy,
  input  logic          pfw_ready,
  input  logic          pfw_value,
  output logic          stall_o,
  output logic          fault_o,
  output logic          fault_fatal,
  output logic [AW-1:0] fault_reg,
  output logic          recov_o,
  output logic [AW-1:0] recov_reg,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_nat
);

  logic [DW-1:0] rf [NREG];
  logic [NREG-1:0] nat;

  assign stall_o = in_valid & pfw_busy & ~pfw_ready;

  wire retire  = in_valid & ~stall_o;
  wire pred_ok = pfw_busy ? pfw_value : (rf[in_pred] != '0);
  wire fire    = retire & pred_ok;

  wire a_bad   = nat[in_src_a];
  wire b_bad   = nat[in_src_b];
  wire exc_res = (in_exc == 2'b01);
  wire exc_fat = in_exc[1];

  logic          do_wr, wr_nat, f_set, f_kind, r_set;
  logic [AW-1:0] f_idx;

  always_comb begin
    do_wr  = 1'b0;
    wr_nat = 1'b0;
    f_set  = 1'b0;
    f_kind = 1'b0;
    f_idx  = in_dst;
    r_set  = 1'b0;
    if (fire) begin
      if (in_chk) begin
        r_set = a_bad;
      end else if (a_bad | b_bad) begin
        if (in_spec) begin
          do_wr  = 1'b1;
          wr_nat = 1'b1;
        end else begin
          f_set  = 1'b1;
          f_kind = 1'b1;
          f_idx  = a_bad ? in_src_a : in_src_b;
        end
      end else if (exc_res) begin
        f_set = 1'b1;
      end else if (exc_fat) begin
        if (in_spec) begin
          do_wr  = 1'b1;
          wr_nat = 1'b1;
        end else begin
          f_set  = 1'b1;
          f_kind = 1'b1;
        end
      end else begin
        do_wr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      nat         <= '0;
      fault_o     <= 1'b0;
      fault_fatal <= 1'b0;
      fault_reg   <= '0;
      recov_o     <= 1'b0;
      recov_reg   <= '0;
    end else begin
      fault_o     <= f_set;
      fault_fatal <= f_kind;
      fault_reg   <= f_idx;
      recov_o     <= r_set;
      recov_reg   <= in_src_a;
      if (do_wr && in_dst != '0) begin
        rf[in_dst]  <= wr_nat ? '0 : in_data;
        nat[in_dst] <= wr_nat;
      end
    end
  end

  assign rd_data = rf[rd_idx];
  assign rd_nat  = nat[rd_idx];

  assert_zero_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == '0) |-> (rd_data == '0 && !rd_nat));

  assert_stall_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> (!fault_o && !recov_o));

  assert_spec_no_fatal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && in_spec && !in_chk) |=> !(fault_o && fault_fatal));

  assert_pred_false_noop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pfw_busy && rf[in_pred] == '0) |=> (!fault_o && !recov_o));

  assert_check_no_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && in_chk) |=> !fault_o);

  assert_clean_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_chk && !in_spec && in_exc == 2'b00 && !a_bad && !b_bad && in_dst != '0)
    |=> (!fault_o && !nat[$past(in_dst)]));

endmodule

// File: tb/spec_commit_bench.sv
module spec_commit_bench;
  localparam int NREG = 16;
  localparam int DW   = 32;
  localparam int AW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_chk = 1'b0, in_spec = 1'b0;
  logic [1:0] in_exc = 2'b00;
  logic [AW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0, in_pred = '0, rd_idx = '0;
  logic [DW-1:0] in_data = '0;
  logic pfw_busy = 1'b0, pfw_ready = 1'b0, pfw_value = 1'b0;
  logic stall_o, fault_o, fault_fatal, recov_o, rd_nat;
  logic [AW-1:0] fault_reg, recov_reg;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  spec_commit #(.NREG(NREG), .DW(DW)) u_spec_commit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chk(in_chk), .in_spec(in_spec),
    .in_exc(in_exc), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_pred(in_pred), .in_data(in_data), .pfw_busy(pfw_busy), .pfw_ready(pfw_ready),
    .pfw_value(pfw_value), .stall_o(stall_o), .fault_o(fault_o), .fault_fatal(fault_fatal),
    .fault_reg(fault_reg), .recov_o(recov_o), .recov_reg(recov_reg), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_nat(rd_nat)
  );

  typedef struct packed {
    logic        chk;
    logic        spec;
    logic [1:0]  exc;
    logic [3:0]  dst;
    logic [3:0]  sa;
    logic [3:0]  sb;
    logic [3:0]  pr;
    logic [1:0]  pfw;
    logic [31:0] data;
    logic        ef;
    logic        ek;
    logic [3:0]  er;
    logic        erc;
    logic [3:0]  ci;
    logic [31:0] ed;
    logic        en;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,2'd0,4'd1,4'd0,4'd0,4'd0,2'd1,32'h1,    1'b0,1'b0,4'd0,1'b0,4'd1, 32'h1,   1'b0,8'd2},  // R2 bypass true
    '{1'b0,1'b0,2'd0,4'd3,4'd0,4'd0,4'd1,2'd0,32'hAAAA, 1'b0,1'b0,4'd0,1'b0,4'd3, 32'hAAAA,1'b0,8'd8},  // R8
    '{1'b0,1'b0,2'd0,4'd4,4'd0,4'd0,4'd2,2'd0,32'h55,   1'b0,1'b0,4'd0,1'b0,4'd4, 32'h0,   1'b0,8'd1},  // R1
    '{1'b0,1'b1,2'd2,4'd5,4'd0,4'd0,4'd1,2'd0,32'h77,   1'b0,1'b0,4'd0,1'b0,4'd5, 32'h0,   1'b1,8'd3},  // R3
    '{1'b0,1'b0,2'd0,4'd6,4'd5,4'd0,4'd1,2'd0,32'h9,    1'b1,1'b1,4'd5,1'b0,4'd6, 32'h0,   1'b0,8'd4},  // R4 src A
    '{1'b0,1'b0,2'd0,4'd6,4'd3,4'd5,4'd1,2'd0,32'h9,    1'b1,1'b1,4'd5,1'b0,4'd6, 32'h0,   1'b0,8'd4},  // R4 src B
    '{1'b0,1'b1,2'd0,4'd7,4'd5,4'd0,4'd1,2'd0,32'h3,    1'b0,1'b0,4'd0,1'b0,4'd7, 32'h0,   1'b1,8'd9},  // R9
    '{1'b1,1'b0,2'd0,4'd0,4'd5,4'd0,4'd1,2'd0,32'h0,    1'b0,1'b0,4'd0,1'b1,4'd5, 32'h0,   1'b1,8'd7},  // R7 poisoned
    '{1'b1,1'b0,2'd0,4'd0,4'd3,4'd0,4'd1,2'd0,32'h0,    1'b0,1'b0,4'd0,1'b0,4'd3, 32'hAAAA,1'b0,8'd7},  // R7 clean
    '{1'b0,1'b0,2'd2,4'd8,4'd0,4'd0,4'd1,2'd0,32'h4,    1'b1,1'b1,4'd8,1'b0,4'd8, 32'h0,   1'b0,8'd5},  // R5
    '{1'b0,1'b1,2'd1,4'd9,4'd0,4'd0,4'd1,2'd0,32'h5,    1'b1,1'b0,4'd9,1'b0,4'd9, 32'h0,   1'b0,8'd6},  // R6 spec
    '{1'b0,1'b0,2'd1,4'd9,4'd0,4'd0,4'd1,2'd0,32'h5,    1'b1,1'b0,4'd9,1'b0,4'd9, 32'h0,   1'b0,8'd6},  // R6 non-spec
    '{1'b0,1'b0,2'd0,4'd5,4'd0,4'd0,4'd1,2'd0,32'h123,  1'b0,1'b0,4'd0,1'b0,4'd5, 32'h123, 1'b0,8'd8},  // R8 clears tag
    '{1'b0,1'b0,2'd0,4'd0,4'd0,4'd0,4'd1,2'd0,32'hFF,   1'b0,1'b0,4'd0,1'b0,4'd0, 32'h0,   1'b0,8'd10}, // R10 write
    '{1'b0,1'b1,2'd2,4'd0,4'd0,4'd0,4'd1,2'd0,32'h0,    1'b0,1'b0,4'd0,1'b0,4'd0, 32'h0,   1'b0,8'd10}, // R10 poison
    '{1'b0,1'b0,2'd0,4'd10,4'd7,4'd0,4'd2,2'd0,32'h8,   1'b0,1'b0,4'd0,1'b0,4'd10,32'h0,   1'b0,8'd1},  // R1 poisoned src
    '{1'b1,1'b0,2'd0,4'd0,4'd7,4'd0,4'd2,2'd0,32'h0,    1'b0,1'b0,4'd0,1'b0,4'd7, 32'h0,   1'b1,8'd1},  // R1 check squashed
    '{1'b0,1'b0,2'd0,4'd11,4'd0,4'd0,4'd1,2'd2,32'h6,   1'b0,1'b0,4'd0,1'b0,4'd11,32'h0,   1'b0,8'd2},  // R2 bypass false
    '{1'b0,1'b0,2'd0,4'd12,4'd0,4'd0,4'd3,2'd0,32'hC,   1'b0,1'b0,4'd0,1'b0,4'd12,32'hC,   1'b0,8'd1}   // R1 nonzero pred
  };

  task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0; in_chk = 1'b0; in_spec = 1'b0; in_exc = 2'b00;
    pfw_busy = 1'b0; pfw_ready = 1'b0; pfw_value = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    in_valid = 1'b1; in_chk = v.chk; in_spec = v.spec; in_exc = v.exc;
    in_dst = v.dst; in_src_a = v.sa; in_src_b = v.sb; in_pred = v.pr; in_data = v.data;
    pfw_busy = (v.pfw != 2'd0); pfw_ready = (v.pfw != 2'd0); pfw_value = (v.pfw == 2'd1);
    rd_idx = v.ci;
    @(negedge clk);
    idle_inputs();
    #1;
    check("fault_o", v.req, fault_o, v.ef);
    if (v.ef) begin
      check("fault_fatal", v.req, fault_fatal, v.ek);
      check("fault_reg", v.req, fault_reg, v.er);
    end
    check("recov_o", v.req, recov_o, v.erc);
    if (v.erc) check("recov_reg", v.req, recov_reg, v.ci);
    check("rd_data", v.req, rd_data, v.ed);
    check("rd_nat", v.req, rd_nat, v.en);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("reset fault_o", 11, fault_o, 1'b0);
    check("reset recov_o", 11, recov_o, 1'b0);
    check("reset stall_o", 11, stall_o, 1'b0);
    for (int r = 0; r < NREG; r++) begin
      rd_idx = AW'(r);
      #1;
      check("reset rd_data", 11, rd_data, 32'h0);
      check("reset rd_nat", 11, rd_nat, 1'b0);
    end

    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // R2 stall until the bypassed predicate is ready
    @(negedge clk);
    in_valid = 1'b1; in_chk = 1'b0; in_spec = 1'b0; in_exc = 2'b00;
    in_dst = 4'd13; in_src_a = 4'd0; in_src_b = 4'd0; in_pred = 4'd2; in_data = 32'h42;
    pfw_busy = 1'b1; pfw_ready = 1'b0; pfw_value = 1'b0;
    rd_idx = 4'd13;
    #1;
    check("stall_o raised", 2, stall_o, 1'b1);
    repeat (3) begin
      @(negedge clk);
      #1;
      check("stall_o held", 2, stall_o, 1'b1);
      check("no write while stalled", 2, rd_data, 32'h0);
      check("no fault while stalled", 2, fault_o, 1'b0);
    end
    pfw_ready = 1'b1; pfw_value = 1'b1;
    #1;
    check("stall_o released", 2, stall_o, 1'b0);
    @(negedge clk);
    idle_inputs();
    #1;
    check("write after release", 2, rd_data, 32'h42);

    // R11 reset in mid-run clears state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_idx = 4'd3;
    #1;
    check("reset clears data", 11, rd_data, 32'h0);
    rd_idx = 4'd7;
    #1;
    check("reset clears tag", 11, rd_nat, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule